// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block sits between a synchronous host and an external asynchronous static memory of 32,768 bytes. The host raises a request with a direction flag, a 15-bit word address and, for writes, one data byte. The block accepts the request when its ready output is high and captures the address and data at that edge. It then drives the memory's active-low chip-enable, output-enable and write-enable strobes through a fixed sequence of phases. Reads end with a one-cycle valid pulse that carries the captured byte.

Each phase lasts a whole number of clock cycles. The count is worked out at elaboration time from the clock period and the memory's minimum timing figures, in picoseconds. The figures used are write-pulse width, address-valid-to-end-of-write, write-cycle time, address and output-enable access times, read-cycle time, and output release time. The data bus is split at the block edge into an output byte, an output-enable and an input byte, and pad logic joins them into the three-state bus. Requests may follow each other without a gap. The only exception is a write that follows a read, which first waits for the memory to release the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset the chip-enable, output-enable and write-enable outputs are high, the data driver enable is low, the read-valid output is low and ready is high.
- R2: The accepted 15-bit address appears on the memory address output throughout the access. A write stores the accepted byte at that address, and a later read of that address returns that byte on the read data output.
- R3: A write holds output-enable high and chip-enable low. It has one setup cycle with write-enable high, then write-enable low for WP cycles, then one cycle with write-enable high again. The data driver is on with the byte steady for all of these cycles. WP is the smallest count of at least 1 where WP clock periods cover the write-pulse width, WP+1 periods cover address-valid-to-end-of-write, and WP+2 periods cover the write-cycle time. At an 8 ns clock, WP is 2.
- R4: A read holds chip-enable and output-enable low and write-enable high for RD cycles, with the driver off. RD is the smallest count of at least 1 whose periods cover the address access, output-enable access and read-cycle times; at an 8 ns clock it is 2. The input byte is captured at the edge that ends the last read cycle. In the next cycle read-valid is high for one cycle with that byte on the read data output.
- R5: The data driver enable is never high while output-enable is low, so the block and the memory never drive the bus at the same time.
- R6: When a write is accepted in the last cycle of a read, TA cycles follow with all three strobes high and the driver off, and then the write setup cycle begins. TA is the output release time divided by the clock period, rounded up, and at least 1; at an 8 ns clock it is 1.
- R7: Ready is high when the block is idle, in the last read cycle and in the final write cycle, and low in every other cycle of an access. A request is taken at a rising edge where request and ready are both high. Host address and data changes after that edge do not reach the memory outputs until the next acceptance.
- R8: A read accepted in the last cycle of a read, or a read accepted in the final write cycle, starts in the very next cycle with chip-enable still low and no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| req_we | input | 1 | Request direction, 1 = write, 0 = read |
| req_addr | input | 15 | Request word address |
| req_wdata | input | 8 | Request write byte |
| ready | output | 1 | Block can take a request in this cycle |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_dq_o | output | 8 | Byte driven onto the memory data bus |
| mem_dq_oe | output | 1 | Driver enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte read from the memory data bus |

## Verification
A phase counter that loads a wrong count shows up on the strobes in the same access. The write-enable low stretch, or the chip- and output-enable low stretch, comes out too long or too short, and the behavioural memory flags a short pulse when write-enable rises. A sequencer that leaves a phase in the wrong direction, or skips the turnaround, drives the bus while output-enable is still low or within one cycle of it. The contention check catches this in that cycle. A wrong address or data latch is only seen later, when the byte read back differs from the reference array on the read-valid cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Sequencer phases.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TURN = 3'd1,
    PH_WSET = 3'd2,
    PH_WSTB = 3'd3,
    PH_WHLD = 3'd4,
    PH_READ = 3'd5
  } phase_e;

  // Registered pin levels driven towards the memory.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } pins_t;

  localparam pins_t PINS_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

  function automatic int unsigned ceil_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  // Write-enable low width: covers pulse, address-valid and whole-cycle minima.
  function automatic int unsigned wr_pulse_cycles(input int unsigned clk_ps,
                                                  input int unsigned t_wp,
                                                  input int unsigned t_aw,
                                                  input int unsigned t_wc);
    int unsigned n;
    n = ceil_cyc(t_wp, clk_ps);
    if (ceil_cyc(t_aw, clk_ps) > n + 1) n = ceil_cyc(t_aw, clk_ps) - 1;
    if (ceil_cyc(t_wc, clk_ps) > n + 2) n = ceil_cyc(t_wc, clk_ps) - 2;
    if (n < 1) n = 1;
    return n;
  endfunction

  // Read phase length: covers address, output-enable and cycle minima.
  function automatic int unsigned rd_cycles(input int unsigned clk_ps,
                                            input int unsigned t_aa,
                                            input int unsigned t_oe,
                                            input int unsigned t_rc);
    int unsigned n;
    n = ceil_cyc(t_aa, clk_ps);
    if (ceil_cyc(t_oe, clk_ps) > n) n = ceil_cyc(t_oe, clk_ps);
    if (ceil_cyc(t_rc, clk_ps) > n) n = ceil_cyc(t_rc, clk_ps);
    if (n < 1) n = 1;
    return n;
  endfunction

  // Idle gap that lets the memory release the bus after a read.
  function automatic int unsigned turn_cycles(input int unsigned clk_ps, input int unsigned t_ohz);
    int unsigned n;
    n = ceil_cyc(t_ohz, clk_ps);
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic pins_t pins_of(input phase_e ph);
    pins_t p;
    p = PINS_QUIET;
    case (ph)
      PH_WSET: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
      PH_WSTB: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};
      PH_WHLD: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
      PH_READ: p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
      default: p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3/R4: an expired counter stays expired until reloaded.
  a_r3_cnt_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CW   = 2,
  parameter int unsigned WP_N = 2,
  parameter int unsigned RD_N = 2,
  parameter int unsigned TA_N = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          cnt_zero,
  output logic          ready,
  output logic          accept,
  output logic          capture,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output pins_t         pins
);

  phase_e ph_q, ph_d;
  logic   enter;
  logic   last_rd;

  assign last_rd = (ph_q == PH_READ) && cnt_zero;
  assign ready   = (ph_q == PH_IDLE) || (ph_q == PH_WHLD) || last_rd;
  assign accept  = req && ready;
  assign capture = last_rd;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (accept) ph_d = req_we ? PH_WSET : PH_READ;
      PH_TURN: if (cnt_zero) ph_d = PH_WSET;
      PH_WSET: ph_d = PH_WSTB;
      PH_WSTB: if (cnt_zero) ph_d = PH_WHLD;
      PH_WHLD: ph_d = accept ? (req_we ? PH_WSET : PH_READ) : PH_IDLE;
      PH_READ: if (cnt_zero) ph_d = accept ? (req_we ? PH_TURN : PH_READ) : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  // A read that chains into another read re-enters its own phase.
  assign enter = (ph_d != ph_q) || (last_rd && ph_d == PH_READ);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (enter) begin
      case (ph_d)
        PH_READ: begin cnt_load = 1'b1; cnt_val = CW'(RD_N - 1); end
        PH_TURN: begin cnt_load = 1'b1; cnt_val = CW'(TA_N - 1); end
        PH_WSTB: begin cnt_load = 1'b1; cnt_val = CW'(WP_N - 1); end
        default: begin cnt_load = 1'b0; cnt_val = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      pins <= PINS_QUIET;
    end else begin
      ph_q <= ph_d;
      pins <= pins_of(ph_d);
    end
  end

  // R4: capture only while the memory is being read.
  a_r4_capture_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!pins.oe_n && !pins.ce_n && pins.we_n));

  // R6: the turnaround phase is only reached from a read.
  a_r6_turn_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TURN) |-> ($past(ph_q) == PH_READ || $past(ph_q) == PH_TURN));

  // R7: no request is taken while write-enable is low.
  a_r7_busy_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !pins.we_n |-> !ready);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= bus_in;
    end
  end

  // R4: returned byte is held between captures.
  a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(rd_data));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW       = 15,
  parameter int unsigned DW       = 8,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_WP_PS  = 10000,
  parameter int unsigned T_AW_PS  = 10000,
  parameter int unsigned T_WC_PS  = 12000,
  parameter int unsigned T_AA_PS  = 12000,
  parameter int unsigned T_OE_PS  = 6000,
  parameter int unsigned T_RC_PS  = 12000,
  parameter int unsigned T_OHZ_PS = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned WP_N  = wr_pulse_cycles(CLK_PS, T_WP_PS, T_AW_PS, T_WC_PS);
  localparam int unsigned RD_N  = rd_cycles(CLK_PS, T_AA_PS, T_OE_PS, T_RC_PS);
  localparam int unsigned TA_N  = turn_cycles(CLK_PS, T_OHZ_PS);
  localparam int unsigned N_MAX = (WP_N > RD_N) ? ((WP_N > TA_N) ? WP_N : TA_N)
                                                : ((RD_N > TA_N) ? RD_N : TA_N);
  localparam int unsigned CW    = $clog2(N_MAX + 1);

  logic          cnt_zero;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          accept;
  logic          capture;
  pins_t         pins;

  asram_seq #(.CW(CW), .WP_N(WP_N), .RD_N(RD_N), .TA_N(TA_N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_we   (req_we),
    .cnt_zero (cnt_zero),
    .ready    (ready),
    .accept   (accept),
    .capture  (capture),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .pins     (pins)
  );

  asram_phase_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .bus_in    (mem_dq_i),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_o),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign mem_ce_n  = pins.ce_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_we_n  = pins.we_n;
  assign mem_dq_oe = pins.drv;

  // Checker-only count of consecutive write-enable low cycles.
  logic [CW:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else               we_run <= '0;
  end

  // R5: never drive while the memory's output may be on.
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R3: write-enable only pulses inside chip-enable, with data driven.
  a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

  // R3: write pulse meets its minimum width and ends before chip-enable.
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ((32'(we_run) >= WP_N) && !mem_ce_n));

  // R6: driver never turns on in the cycle right after output-enable was low.
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> $past(mem_oe_n));

  // R4: valid pulse only follows a cycle of reading.
  a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

  // R7: address is frozen during an access unless a new request is taken.
  a_r7_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_ce_n) && !$past(accept)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int CLK_PS = 8000;

  function automatic int exp_wp();
    for (int n = 1; n < 100; n++)
      if (n*CLK_PS >= 10000 && (n+1)*CLK_PS >= 10000 && (n+2)*CLK_PS >= 12000) return n;
    return 100;
  endfunction
  function automatic int exp_rd();
    for (int n = 1; n < 100; n++)
      if (n*CLK_PS >= 12000 && n*CLK_PS >= 6000) return n;
    return 100;
  endfunction
  function automatic int exp_ta();
    for (int n = 1; n < 100; n++)
      if (n*CLK_PS >= 6000) return n;
    return 100;
  endfunction

  localparam int WP_EXP = exp_wp();
  localparam int RD_EXP = exp_rd();
  localparam int TA_EXP = exp_ta();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  always #4 clk = ~clk;

  asram_ctrl #(.CLK_PS(CLK_PS)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural memory: 64 slots tagged with the full address.
  logic [14:0] m_tag [64];
  logic [7:0]  m_dat [64];
  bit          m_vld [64];
  logic [14:0] r_tag [64];
  logic [7:0]  r_dat [64];
  bit          r_vld [64];

  logic        mem_on;
  logic [7:0]  mem_byte;
  assign mem_on   = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_byte = (m_vld[mem_addr[5:0]] && m_tag[mem_addr[5:0]] == mem_addr) ? m_dat[mem_addr[5:0]] : 8'hEE;
  assign mem_dq_i = mem_dq_oe ? mem_dq_o : (mem_on ? mem_byte : 8'h00);

  function automatic logic [7:0] ref_get(input logic [14:0] a);
    return (r_vld[a[5:0]] && r_tag[a[5:0]] == a) ? r_dat[a[5:0]] : 8'hEE;
  endfunction
  task automatic ref_put(input logic [14:0] a, input logic [7:0] d);
    r_vld[a[5:0]] = 1'b1; r_tag[a[5:0]] = a; r_dat[a[5:0]] = d;
  endtask

  int          we_run = 0;
  logic [14:0] w_addr;
  logic [7:0]  w_dat;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && mem_ce_n) chk("R3 model: write-enable low outside chip-enable", 1, 0);
      if (mem_dq_oe && mem_on)   chk("R5 model: bus contention", 1, 0);
      if (!mem_we_n && !mem_ce_n) begin
        if (!mem_dq_oe) chk("R3 model: data not driven in write", 0, 1);
        if (we_run == 0) begin
          w_addr = mem_addr; w_dat = mem_dq_o;
        end else if (mem_addr !== w_addr || mem_dq_o !== w_dat) begin
          chk("R3 model: address or data moved in write", {9'd0, mem_addr, mem_dq_o}, {9'd0, w_addr, w_dat});
        end
        we_run++;
      end else if (we_run != 0) begin
        chk("R3 model: write pulse width", (we_run >= WP_EXP), 1);
        m_vld[w_addr[5:0]] = 1'b1; m_tag[w_addr[5:0]] = w_addr; m_dat[w_addr[5:0]] = w_dat;
        we_run = 0;
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  // Present a request; return in the first cycle after acceptance.
  task automatic start(input bit we, input logic [14:0] a, input logic [7:0] d);
    while (!ready) step();
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    step();
    req = 1'b0; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic t_reset();
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 driver", mem_dq_oe, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ready", ready, 1);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    start(1'b1, a, d);
    ref_put(a, d);
    chk("R3 setup pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0111);
    chk("R7 busy in setup", ready, 0);
    chk("R2 write addr", mem_addr, a);
    chk("R2 write data", mem_dq_o, d);
    for (int i = 0; i < WP_EXP; i++) begin
      step();
      chk("R3 strobe pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0101);
      chk("R7 busy in strobe", ready, 0);
      chk("R7 addr held", mem_addr, a);
    end
    step();
    chk("R3 recovery pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0111);
    chk("R7 ready in last write cycle", ready, 1);
    step();
    chk("R3 idle after write", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
  endtask

  task automatic t_read(input logic [14:0] a);
    logic [7:0] e;
    e = ref_get(a);
    start(1'b0, a, 8'h00);
    for (int i = 0; i < RD_EXP; i++) begin
      if (i > 0) step();
      chk("R4 read pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
      chk("R4 no early valid", rd_valid, 0);
      chk("R2 read addr", mem_addr, a);
      chk("R7 ready only in last read cycle", ready, (i == RD_EXP-1));
    end
    step();
    chk("R4 valid pulse", rd_valid, 1);
    chk("R2 read data", rd_data, e);
    chk("R4 idle after read", {mem_ce_n, mem_oe_n}, 2'b11);
    step();
    chk("R4 valid one cycle", rd_valid, 0);
  endtask

  task automatic t_rd_then_wr(input logic [14:0] ra, input logic [14:0] wa, input logic [7:0] wd);
    logic [7:0] e;
    e = ref_get(ra);
    start(1'b0, ra, 8'h00);
    repeat (RD_EXP-1) step();
    req = 1'b1; req_we = 1'b1; req_addr = wa; req_wdata = wd;
    step();
    req = 1'b0; req_addr = '0; req_wdata = '0;
    ref_put(wa, wd);
    chk("R4 valid before turnaround", rd_valid, 1);
    chk("R2 read data before write", rd_data, e);
    for (int i = 0; i < TA_EXP; i++) begin
      if (i > 0) step();
      chk("R6 turnaround pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
      chk("R6 busy in turnaround", ready, 0);
    end
    step();
    chk("R6 write setup after gap", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0111);
    repeat (WP_EXP + 2) step();
  endtask

  task automatic t_rd_rd(input logic [14:0] a1, input logic [14:0] a2);
    logic [7:0] e1, e2;
    e1 = ref_get(a1); e2 = ref_get(a2);
    start(1'b0, a1, 8'h00);
    repeat (RD_EXP-1) step();
    req = 1'b1; req_we = 1'b0; req_addr = a2;
    step();
    req = 1'b0;
    chk("R8 chip-enable stays low read to read", {mem_ce_n, mem_oe_n}, 2'b00);
    chk("R8 second addr", mem_addr, a2);
    chk("R4 first valid", rd_valid, 1);
    chk("R2 first data", rd_data, e1);
    repeat (RD_EXP) step();
    chk("R4 second valid", rd_valid, 1);
    chk("R2 second data", rd_data, e2);
    step();
  endtask

  task automatic t_wr_rd(input logic [14:0] a, input logic [7:0] d);
    start(1'b1, a, d);
    ref_put(a, d);
    repeat (WP_EXP + 1) step();
    chk("R7 ready in final write cycle", ready, 1);
    req = 1'b1; req_we = 1'b0; req_addr = a;
    step();
    req = 1'b0;
    chk("R8 read right after write", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
    repeat (RD_EXP) step();
    chk("R4 valid after write-read", rd_valid, 1);
    chk("R2 write-read data", rd_data, d);
    step();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_vld[i] = 1'b0; r_vld[i] = 1'b0; end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_write(15'h0000, 8'h00);
    t_write(15'h7FFF, 8'hFF);
    t_write(15'h1234, 8'hA5);
    t_write(15'h4321, 8'h5A);
    t_read(15'h0000);
    t_read(15'h7FFF);
    t_read(15'h1234);
    t_read(15'h4321);
    t_rd_then_wr(15'h1234, 15'h2A0B, 8'h3C);
    t_read(15'h2A0B);
    t_rd_rd(15'h7FFF, 15'h4321);
    t_wr_rd(15'h5555, 8'hC3);
    t_write(15'h0000, 8'h81);
    t_read(15'h0000);
    repeat (2) step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule